// File: doc/BRIEF.md
# DDR2 Power-Down Sequencer

This block sits on the controller side of a DDR2 interface. It owns the clock-enable pin and decides when the memory may enter or leave power-down. When the scheduler goes idle and raises `idle_req_i`, the sequencer drops CKE while it forces a NOP/deselect slot. Entry waits while a mode-register access, a read or a write is still running. Row activation, precharge and refresh may still be finishing when CKE drops.

At entry the sequencer records whether any bank holds an open row, which makes this an active power-down, or none does, which makes it a precharge power-down. It also records the exit-speed setting. These two values pick the exit latency and the reported DLL state. CKE stays low for at least the programmed minimum pulse. The block returns CKE high when the idle request drops or the refresh scheduler demands an exit. It also forces an exit before the residency reaches nine refresh intervals. After CKE rises it keeps the command slot forced to NOP until the selected exit latency has elapsed, then raises `cmd_rdy_o`. A new entry also waits until CKE has been high for the minimum pulse. Every timing value is a run-time cycle count.

Top module: `pd_seq`

## Requirements
- R1: After reset, `cke_o`=1, `cmd_rdy_o`=1, `nop_o`=0, `pd_act_o`=0 and `dll_en_o`=1.
- R2: In the ready state, a clock edge that sees `idle_req_i`=1 with entry allowed moves the block to power-down. From the next cycle `cke_o`=0, `nop_o`=1 and `cmd_rdy_o`=0.
- R3: Encoding of `busy_i`: bit0 mode-register, bit1 read, bit2 write, bit3 activate, bit4 precharge, bit5 refresh. Any of bits 0..2 set blocks entry. Bits 3..5 have no effect on entry.
- R4: `pd_act_o` is 1 for active power-down (some bit of `bank_open_i` set at entry) and 0 for precharge power-down. The value is taken at entry and held until `cmd_rdy_o` returns, even if the bank state changes. It is 0 while ready.
- R5: `dll_en_o` is 0 in precharge power-down and in slow-exit active power-down (`fast_exit_i`=0 at entry). It is 1 in fast-exit active power-down and while ready. The value holds through the exit phase.
- R6: Once low, `cke_o` stays low for at least `t_cke_i` cycles, provided `t_cke_i` is below nine refresh intervals.
- R7: After the minimum low time, `idle_req_i`=0 or `exit_req_i`=1 raises `cke_o` on the next edge. While it does, `nop_o` stays 1 and `cmd_rdy_o` stays 0.
- R8: CKE-low residency never reaches 9·`t_refi_i` cycles. With `idle_req_i` held, exit is forced after 9·`t_refi_i`−1 low cycles.
- R9: After CKE rises, `cmd_rdy_o` returns after exactly L high cycles. L is `t_xp_i` for precharge, `t_xard_i` for fast-exit active and `t_xards_i` for slow-exit active power-down.
- R10: A new entry is not taken until CKE has been high for at least `t_cke_i` cycles.
- R11: `exit_req_i`=1 takes priority over `idle_req_i`. While it is high, no entry happens.
- R12: A zero in any timing input acts as one cycle.
- R13: `nop_o` is 1 in every cycle from entry until `cmd_rdy_o` returns, and 0 while ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Controller clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| idle_req_i | input | 1 | Scheduler idle, power-down wanted |
| exit_req_i | input | 1 | Forced exit from refresh scheduler |
| bank_open_i | input | NB | Per-bank open-row flags |
| busy_i | input | 6 | Operation-in-flight flags (see R3) |
| fast_exit_i | input | 1 | 1 = fast exit for active power-down |
| t_cke_i | input | TW | Minimum CKE pulse, cycles |
| t_xp_i | input | TW | Precharge power-down exit latency |
| t_xard_i | input | TW | Fast-exit active exit latency |
| t_xards_i | input | TW | Slow-exit active exit latency |
| t_refi_i | input | RW | Refresh interval, cycles |
| cke_o | output | 1 | Clock enable to DRAM |
| nop_o | output | 1 | Force NOP/deselect in the command slot |
| cmd_rdy_o | output | 1 | Scheduler may issue commands |
| pd_act_o | output | 1 | 1 = active, 0 = precharge power-down |
| dll_en_o | output | 1 | DLL reported enabled |

## Verification
The bench builds the block with NB=4, TW=8 and RW=8. Every timing input is driven to a small value: tCKE 3 (5 in one case), tXP 2, tXARD 4, tXARDS 6 and tREFI 2. With these values the three exit latencies are distinct, so a wrong latency choice changes the observed cycle count. The nine-interval limit falls at 17 low cycles, short enough to reach within one directed scenario. A tCKE longer than the exit latency makes the re-entry hold visible as extra ready cycles. Zeros on the timing inputs exercise the one-cycle floor.

// File: rtl/pd_seq_pkg.sv
package pd_seq_pkg;
  localparam int BUSY_W = 6;
  localparam int BZ_MRS = 0;
  localparam int BZ_RD  = 1;
  localparam int BZ_WR  = 2;
  // background ops (act, pre, ref) on bits 3..5 do not block entry
  localparam logic [BUSY_W-1:0] BLOCK_MASK = 6'b000111;

  typedef enum logic [1:0] {
    ST_RUN = 2'd0,
    ST_PD  = 2'd1,
    ST_XIT = 2'd2
  } pd_state_e;
endpackage

// File: rtl/pd_span.sv
module pd_span #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  output logic [W-1:0] cnt_o
);
  // saturating cycle counter, clear loads 1 (first cycle of the span)
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_o <= '1;
    else if (clr_i)          cnt_o <= W'(1);
    else if (cnt_o != '1)    cnt_o <= cnt_o + W'(1);
  end
endmodule

// File: rtl/pd_exit_lat.sv
module pd_exit_lat #(
  parameter int TW = 8
) (
  input  logic          act_i,
  input  logic          fast_i,
  input  logic [TW-1:0] t_xp_i,
  input  logic [TW-1:0] t_xard_i,
  input  logic [TW-1:0] t_xards_i,
  output logic [TW-1:0] lat_o
);
  localparam int NLAT = 3;

  logic [TW-1:0] raw [NLAT];
  logic [TW-1:0] eff [NLAT];
  logic [1:0]    sel;

  assign raw[0] = t_xp_i;
  assign raw[1] = t_xard_i;
  assign raw[2] = t_xards_i;

  for (genvar g = 0; g < NLAT; g++) begin : g_clamp
    assign eff[g] = (raw[g] == '0) ? TW'(1) : raw[g];
  end

  assign sel   = !act_i ? 2'd0 : (fast_i ? 2'd1 : 2'd2);
  assign lat_o = eff[sel];
endmodule

// File: rtl/pd_seq.sv
module pd_seq
  import pd_seq_pkg::*;
#(
  parameter int NB = 8,
  parameter int TW = 8,
  parameter int RW = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              idle_req_i,
  input  logic              exit_req_i,
  input  logic [NB-1:0]     bank_open_i,
  input  logic [BUSY_W-1:0] busy_i,
  input  logic              fast_exit_i,
  input  logic [TW-1:0]     t_cke_i,
  input  logic [TW-1:0]     t_xp_i,
  input  logic [TW-1:0]     t_xard_i,
  input  logic [TW-1:0]     t_xards_i,
  input  logic [RW-1:0]     t_refi_i,
  output logic              cke_o,
  output logic              nop_o,
  output logic              cmd_rdy_o,
  output logic              pd_act_o,
  output logic              dll_en_o
);
  localparam int LW = RW + 4;  // holds 9 * tREFI

  pd_state_e     state_q, state_d;
  logic          act_q, fast_q;
  logic [TW-1:0] t_cke_eff, lat;
  logic [RW-1:0] refi_eff;
  logic [LW-1:0] lim, lo_cnt;
  logic [TW-1:0] hi_cnt;
  logic          blocked, lo_ok, res_max, hi_ok;
  logic          entry_go, exit_go, lat_done;

  assign t_cke_eff = (t_cke_i == '0) ? TW'(1) : t_cke_i;
  assign refi_eff  = (t_refi_i == '0) ? RW'(1) : t_refi_i;
  assign lim       = LW'(refi_eff) * LW'(9);

  assign blocked  = |(busy_i & BLOCK_MASK);
  assign hi_ok    = hi_cnt >= t_cke_eff;
  assign lo_ok    = lo_cnt >= LW'(t_cke_eff);
  assign res_max  = lo_cnt >= (lim - LW'(1));
  assign entry_go = idle_req_i && !exit_req_i && !blocked && hi_ok;
  assign exit_go  = res_max || (lo_ok && (exit_req_i || !idle_req_i));
  assign lat_done = hi_cnt >= lat;

  pd_span #(.W(LW)) u_lo (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (state_q == ST_RUN && entry_go),
    .cnt_o (lo_cnt)
  );

  pd_span #(.W(TW)) u_hi (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (state_q == ST_PD && exit_go),
    .cnt_o (hi_cnt)
  );

  pd_exit_lat #(.TW(TW)) u_lat (
    .act_i    (act_q),
    .fast_i   (fast_q),
    .t_xp_i   (t_xp_i),
    .t_xard_i (t_xard_i),
    .t_xards_i(t_xards_i),
    .lat_o    (lat)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_RUN:  if (entry_go) state_d = ST_PD;
      ST_PD:   if (exit_go)  state_d = ST_XIT;
      ST_XIT:  if (lat_done) state_d = ST_RUN;
      default: state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_RUN;
      act_q   <= 1'b0;
      fast_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_RUN && entry_go) begin
        act_q  <= |bank_open_i;
        fast_q <= fast_exit_i;
      end
    end
  end

  assign cke_o     = (state_q != ST_PD);
  assign nop_o     = (state_q != ST_RUN);
  assign cmd_rdy_o = (state_q == ST_RUN);
  assign pd_act_o  = (state_q != ST_RUN) && act_q;
  assign dll_en_o  = (state_q == ST_RUN) || (act_q && fast_q);

  assert_block_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cke_o && (busy_i[BZ_MRS] || busy_i[BZ_RD] || busy_i[BZ_WR])) |=> cke_o);

  assert_min_low_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cke_o && lo_cnt < LW'(t_cke_eff) && lo_cnt < lim - LW'(1)) |=> !cke_o);

  assert_exit_nop_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cke_o) |-> (nop_o && !cmd_rdy_o));

  assert_max_res_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cke_o |-> (lo_cnt < lim));

  assert_exit_lat_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cmd_rdy_o) |-> ($past(hi_cnt) >= $past(lat)));

  assert_type_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cmd_rdy_o && $past(!cmd_rdy_o)) |-> ($stable(pd_act_o) && $stable(dll_en_o)));

  assert_reentry_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cke_o) |-> ($past(hi_cnt) >= $past(t_cke_eff)));

  assert_prio_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_rdy_o && exit_req_i) |=> cke_o);
endmodule

// File: tb/sim_pd_seq.sv
`timescale 1ns/1ps
module sim_pd_seq;
  localparam int NB = 4;
  localparam int TW = 8;
  localparam int RW = 8;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          idle_req = 1'b0, exit_req = 1'b0, fast_exit = 1'b0;
  logic [NB-1:0] bank_open = '0;
  logic [5:0]    busy = '0;
  logic [TW-1:0] t_cke = 8'd3, t_xp = 8'd2, t_xard = 8'd4, t_xards = 8'd6;
  logic [RW-1:0] t_refi = 8'd2;
  logic          cke, nop, rdy, pact, dll;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;  // 125 MHz

  pd_seq #(.NB(NB), .TW(TW), .RW(RW)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .idle_req_i(idle_req), .exit_req_i(exit_req),
    .bank_open_i(bank_open), .busy_i(busy), .fast_exit_i(fast_exit),
    .t_cke_i(t_cke), .t_xp_i(t_xp), .t_xard_i(t_xard), .t_xards_i(t_xards),
    .t_refi_i(t_refi), .cke_o(cke), .nop_o(nop), .cmd_rdy_o(rdy),
    .pd_act_o(pact), .dll_en_o(dll)
  );

  // {cke, nop, rdy, pd_act, dll}
  localparam logic [4:0] E_RUN = 5'b10101;
  localparam logic [4:0] E_PDP = 5'b01000;
  localparam logic [4:0] E_XPP = 5'b11000;
  localparam logic [4:0] E_PDF = 5'b01011;
  localparam logic [4:0] E_XPF = 5'b11011;
  localparam logic [4:0] E_PDS = 5'b01010;
  localparam logic [4:0] E_XPS = 5'b11010;

  logic [4:0] exp_q [$];
  string      tag_q [$];

  task automatic cyc(input logic [4:0] e, input string tag, input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      exp_q.push_back(e);
      tag_q.push_back(tag);
    end
  endtask

  // monitor: pops expectations and compares
  always @(negedge clk) begin
    #1;
    while (exp_q.size() > 0) begin
      logic [4:0] e, a;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      a = {cke, nop, rdy, pact, dll};
      n_chk++;
      if (a !== e) begin
        n_fail++;
        $display("FAIL %s: got cke/nop/rdy/act/dll=%b expected %b at %0t", t, a, e, $time);
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    cyc(E_RUN, "R1 reset state");

    // R2 R6 R7 R9 R13: precharge entry, exit on idle drop, tXP=2
    idle_req = 1;
    cyc(E_PDP, "R2 entry precharge", 5);
    idle_req = 0;
    cyc(E_XPP, "R7 R13 exit nop", 2);
    cyc(E_RUN, "R9 tXP ready");

    // R6: minimum low time
    idle_req = 1;
    cyc(E_PDP, "R2 entry");
    idle_req = 0;
    cyc(E_PDP, "R6 min low hold", 2);
    cyc(E_XPP, "R6 exit after tCKE", 2);
    cyc(E_RUN, "R9 ready");

    // R3: blocking ops
    idle_req = 1;
    busy = 6'b000010;
    cyc(E_RUN, "R3 read blocks", 2);
    busy = 6'b000001;
    cyc(E_RUN, "R3 mode-reg blocks");
    busy = 6'b000100;
    cyc(E_RUN, "R3 write blocks");
    busy = 6'b111000;
    cyc(E_PDP, "R3 background ops allow");
    busy = 6'b000000;
    idle_req = 0;
    cyc(E_PDP, "R6 hold", 2);
    cyc(E_XPP, "R7 exit", 2);
    cyc(E_RUN, "R9 ready");

    // R11: exit request beats idle request
    idle_req = 1;
    exit_req = 1;
    cyc(E_RUN, "R11 no entry", 3);

    // R10 R11 R7: forced exit, re-entry hold with tCKE=5
    exit_req = 0;
    t_cke = 8'd5;
    cyc(E_PDP, "R2 entry");
    exit_req = 1;
    cyc(E_PDP, "R6 hold tCKE=5", 4);
    cyc(E_XPP, "R11 forced exit");
    exit_req = 0;
    cyc(E_XPP, "R9 latency");
    cyc(E_RUN, "R10 reentry held", 3);
    cyc(E_PDP, "R10 reentry after tCKE high");
    idle_req = 0;
    cyc(E_PDP, "R6 hold", 4);
    cyc(E_XPP, "R7 exit", 2);
    cyc(E_RUN, "R9 ready");
    t_cke = 8'd3;
    cyc(E_RUN, "R10 settle", 3);

    // R4 R5 R9: fast-exit active, tXARD=4, bank change ignored
    bank_open = 4'b0100;
    fast_exit = 1;
    idle_req = 1;
    cyc(E_PDF, "R4 R5 active fast entry");
    bank_open = 4'b0000;
    cyc(E_PDF, "R4 type latched");
    idle_req = 0;
    cyc(E_PDF, "R5 fast dll on");
    cyc(E_XPF, "R9 tXARD", 4);
    cyc(E_RUN, "R9 ready after tXARD");

    // R4 R5 R9: slow-exit active, tXARDS=6, fast toggle ignored
    bank_open = 4'b0001;
    fast_exit = 0;
    idle_req = 1;
    cyc(E_PDS, "R4 R5 active slow entry");
    fast_exit = 1;
    idle_req = 0;
    cyc(E_PDS, "R5 slow dll off", 2);
    cyc(E_XPS, "R9 tXARDS", 6);
    cyc(E_RUN, "R9 ready after tXARDS");
    bank_open = '0;
    fast_exit = 0;

    // R8: residency limit 9*2 -> forced exit after 17 low cycles
    idle_req = 1;
    cyc(E_PDP, "R8 residency", 17);
    cyc(E_XPP, "R8 forced exit", 2);
    cyc(E_RUN, "R9 ready");
    cyc(E_PDP, "R10 reentry");
    idle_req = 0;
    cyc(E_PDP, "R6 hold", 2);
    cyc(E_XPP, "R7 exit", 2);
    cyc(E_RUN, "R9 ready");

    // R12: zero timing values act as 1
    t_cke = 8'd0;
    t_xp = 8'd0;
    idle_req = 1;
    cyc(E_PDP, "R12 entry");
    idle_req = 0;
    cyc(E_XPP, "R12 one-cycle low and latency");
    cyc(E_RUN, "R12 ready");

    repeat (3) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule